// File: doc/BRIEF.md
# Barrel Shifter with Carry and Extend Flags

This block is a purely combinational shifter for a processor's integer datapath. It takes an operand, a shift amount, a two-bit operation code and the carry flag as it was before the instruction. In the same cycle it produces the shifted value, the new carry flag and the new extend flag. Three shift kinds are supported: logical left, logical right and arithmetic right.

The shift amount is never wrapped modulo the operand width. Amounts equal to or larger than the width have defined results. An amount of zero leaves the operand unchanged and keeps the carry flag as it was. The negative and zero flags are derived from the result outside this block.

The block has no state machine and no clock. Its single operating "state" is the combinational path, chosen by the operation code. The transitions are the four operation codes: left, logical right, arithmetic right and reserved. Each of them selects a result and carry source in one mux level.

Top module: `shift_flag_unit`

## Requirements
- R1: The operation code selects the kind of shift: 2'b00 is logical left, 2'b01 is logical right, 2'b10 is arithmetic right. The amount is the full AMT_W-bit field and is never reduced modulo WIDTH.
- R2: When the amount is zero and the operation code is a shift code, the result equals the operand and carry_out equals carry_in.
- R3: For a left shift by n with 1 <= n < WIDTH, the result is the operand shifted left by n with zeros entering at bit 0, and carry_out is operand bit WIDTH-n.
- R4: For a left shift by exactly WIDTH, the result is zero and carry_out is operand bit 0. For a left shift by more than WIDTH, the result and carry_out are both zero.
- R5: For a logical right shift by n with 1 <= n < WIDTH, zeros enter at the top and carry_out is operand bit n-1.
- R6: For a logical right shift by exactly WIDTH, the result is zero and carry_out is operand bit WIDTH-1. For a logical right shift by more than WIDTH, the result and carry_out are both zero.
- R7: For an arithmetic right shift by n with 1 <= n < WIDTH, copies of operand bit WIDTH-1 enter at the top and carry_out is operand bit n-1.
- R8: For an arithmetic right shift by WIDTH or more, every result bit equals operand bit WIDTH-1, and carry_out equals operand bit WIDTH-1.
- R9: extend_out equals carry_out for every input combination.
- R10: The reserved operation code 2'b11 returns the operand unchanged and passes carry_in to carry_out, whatever the amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand | input | WIDTH | Value to shift |
| amount | input | AMT_W | Shift distance, used in full |
| op | input | 2 | Operation code: 00 left, 01 logical right, 10 arithmetic right, 11 reserved |
| carry_in | input | 1 | Carry flag before the instruction |
| result | output | WIDTH | Shifted value |
| carry_out | output | 1 | New carry flag |
| extend_out | output | 1 | New extend flag, a copy of the new carry |

## Verification
The bench builds one copy with WIDTH=8 and AMT_W=4. On that copy it sweeps every operand, every amount from 0 to 15, all four operation codes and both carry_in values. That sweep covers the below-width, exactly-width and above-width amounts for every shift kind. A second copy with the default WIDTH=32 and AMT_W=6 receives directed vectors at amounts 0, 1, 31, 32, 33 and 63. These vectors confirm the same boundary rules at full width, where the sign bit and the carry bit sit far apart.

// File: rtl/shift_flag_pkg.sv
package shift_flag_pkg;
    typedef enum logic [1:0] {
        SH_LEFT  = 2'b00,
        SH_LOGR  = 2'b01,
        SH_ARIR  = 2'b10,
        SH_RSVD  = 2'b11
    } shift_op_e;
endpackage

// File: rtl/shift_left_stage.sv
module shift_left_stage #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 6
) (
    input  logic [WIDTH-1:0] din,
    input  logic [AMT_W-1:0] amt,
    output logic [WIDTH-1:0] dout,
    output logic             cout
);
    localparam int EXT_W = WIDTH + 1;

    // One guard bit above the operand catches the last bit shifted out.
    logic [EXT_W-1:0] stage [0:AMT_W];

    assign stage[0] = {1'b0, din};

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam longint STEP = longint'(1) << k;
        if (STEP >= EXT_W) begin : g_flush
            assign stage[k+1] = amt[k] ? '0 : stage[k];
        end else begin : g_move
            assign stage[k+1] = amt[k] ? (stage[k] << STEP) : stage[k];
        end
    end

    assign dout = stage[AMT_W][WIDTH-1:0];
    assign cout = stage[AMT_W][WIDTH];
endmodule

// File: rtl/shift_right_stage.sv
module shift_right_stage #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 6
) (
    input  logic [WIDTH-1:0] din,
    input  logic [AMT_W-1:0] amt,
    input  logic             arith,
    output logic [WIDTH-1:0] dout,
    output logic             cout
);
    localparam int EXT_W = WIDTH + 1;

    logic             fill;
    logic [EXT_W-1:0] stage [0:AMT_W];

    assign fill     = arith & din[WIDTH-1];
    // One guard bit below the operand catches the last bit shifted out.
    assign stage[0] = {din, 1'b0};

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam longint STEP = longint'(1) << k;
        if (STEP >= EXT_W) begin : g_flush
            assign stage[k+1] = amt[k] ? {EXT_W{fill}} : stage[k];
        end else begin : g_move
            logic [EXT_W-1:0] top_mask;
            assign top_mask   = ~({EXT_W{1'b1}} >> STEP);
            assign stage[k+1] = amt[k] ? ((stage[k] >> STEP) | (fill ? top_mask : '0))
                                       : stage[k];
        end
    end

    assign dout = stage[AMT_W][EXT_W-1:1];
    assign cout = stage[AMT_W][0];
endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 6
) (
    input  logic [WIDTH-1:0] operand,
    input  logic [AMT_W-1:0] amount,
    input  logic [1:0]       op,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             extend_out
);
    import shift_flag_pkg::*;

    localparam longint AMT_MAX = (longint'(1) << AMT_W) - 1;

    shift_op_e        op_sel;
    logic             amt_zero;
    logic [WIDTH-1:0] left_val;
    logic             left_cy;
    logic [WIDTH-1:0] right_val;
    logic             right_cy;

    assign op_sel   = shift_op_e'(op);
    assign amt_zero = (amount == '0);

    shift_left_stage #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_left (
        .din  (operand),
        .amt  (amount),
        .dout (left_val),
        .cout (left_cy)
    );

    shift_right_stage #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_right (
        .din   (operand),
        .amt   (amount),
        .arith (op_sel == SH_ARIR),
        .dout  (right_val),
        .cout  (right_cy)
    );

    // R1: operation code picks the path; R2/R10: zero amount or reserved keeps inputs.
    always_comb begin
        result    = operand;
        carry_out = carry_in;
        unique case (op_sel)
            SH_LEFT: begin
                if (!amt_zero) begin
                    result    = left_val;
                    carry_out = left_cy;
                end
            end
            SH_LOGR, SH_ARIR: begin
                if (!amt_zero) begin
                    result    = right_val;
                    carry_out = right_cy;
                end
            end
            SH_RSVD: begin
                result    = operand;
                carry_out = carry_in;
            end
            default: begin
                result    = operand;
                carry_out = carry_in;
            end
        endcase
    end

    // R9: extend follows the new carry.
    assign extend_out = carry_out;

    always_comb begin
        if (!$isunknown({operand, amount, op, carry_in})) begin
            if (amt_zero)
                p_zero_keeps_r2: assert (result == operand && carry_out == carry_in)
                    else $error("R2 zero amount altered outputs");
            if (op_sel == SH_RSVD)
                p_reserved_pass_r10: assert (result == operand && carry_out == carry_in)
                    else $error("R10 reserved code altered outputs");
            if (op_sel == SH_LEFT && longint'(amount) > WIDTH)
                p_left_flush_r4: assert (result == '0 && !carry_out)
                    else $error("R4 left beyond width not cleared");
            if (op_sel == SH_LOGR && longint'(amount) > WIDTH)
                p_logr_flush_r6: assert (result == '0 && !carry_out)
                    else $error("R6 right beyond width not cleared");
            if (op_sel == SH_ARIR && longint'(amount) >= WIDTH && longint'(amount) <= AMT_MAX)
                p_arir_sign_r8: assert (result == {WIDTH{operand[WIDTH-1]}}
                                        && carry_out == operand[WIDTH-1])
                    else $error("R8 arithmetic saturation wrong");
            p_ext_tracks_r9: assert (extend_out == carry_out)
                else $error("R9 extend differs from carry");
        end
    end
endmodule

// File: tb/shift_flag_unit_test.sv
module shift_flag_unit_test;
    localparam int SW = 8;
    localparam int SA = 4;
    localparam int BW = 32;
    localparam int BA = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [SW-1:0] s_opnd;
    logic [SA-1:0] s_amt;
    logic [1:0]    s_op;
    logic          s_cin;
    logic [SW-1:0] s_res;
    logic          s_cy, s_ext;

    logic [BW-1:0] b_opnd;
    logic [BA-1:0] b_amt;
    logic [1:0]    b_op;
    logic          b_cin;
    logic [BW-1:0] b_res;
    logic          b_cy, b_ext;

    shift_flag_unit #(.WIDTH(SW), .AMT_W(SA)) uut (
        .operand(s_opnd), .amount(s_amt), .op(s_op), .carry_in(s_cin),
        .result(s_res), .carry_out(s_cy), .extend_out(s_ext));

    shift_flag_unit #(.WIDTH(BW), .AMT_W(BA)) uut_wide (
        .operand(b_opnd), .amount(b_amt), .op(b_op), .carry_in(b_cin),
        .result(b_res), .carry_out(b_cy), .extend_out(b_ext));

    // Reference model from the requirements; values held in 64 bits, width w.
    function automatic void model(input longint unsigned x, input int c, input int op,
                                  input bit cin, input int w,
                                  output longint unsigned r, output bit cy,
                                  output string tag);
        longint unsigned mask;
        bit sgn;
        mask = (w == 64) ? '1 : ((longint'(1) << w) - 1);
        x    = x & mask;
        sgn  = x[w-1];
        if (op == 3) begin
            r = x; cy = cin; tag = "R10";
        end else if (c == 0) begin
            r = x; cy = cin; tag = "R2";
        end else if (op == 0) begin
            if (c < w)       begin r = (x << c) & mask; cy = x[w-c]; tag = "R3"; end
            else if (c == w) begin r = 0; cy = x[0]; tag = "R4"; end
            else             begin r = 0; cy = 1'b0; tag = "R4"; end
        end else if (op == 1) begin
            if (c < w)       begin r = x >> c; cy = x[c-1]; tag = "R5"; end
            else if (c == w) begin r = 0; cy = x[w-1]; tag = "R6"; end
            else             begin r = 0; cy = 1'b0; tag = "R6"; end
        end else begin
            if (c < w) begin
                r = x >> c;
                if (sgn) r = r | (mask & ~(mask >> c));
                cy = x[c-1]; tag = "R7";
            end else begin
                r = sgn ? mask : 0; cy = sgn; tag = "R8";
            end
        end
    endfunction

    task automatic judge(input string tag, input longint unsigned got_r, input bit got_c,
                         input bit got_e, input longint unsigned exp_r, input bit exp_c);
        total++;
        if (got_r !== exp_r || got_c !== exp_c) begin
            bad++;
            $display("FAIL %s (R1 op select) result=%h carry=%b expected result=%h carry=%b",
                     tag, got_r, got_c, exp_r, exp_c);
        end
        total++;
        if (got_e !== exp_c) begin
            bad++;
            $display("FAIL R9 extend=%b expected=%b", got_e, exp_c);
        end
    endtask

    task automatic wide_vec(input logic [BW-1:0] x, input int c, input int op, input bit cin);
        longint unsigned er;
        bit ec;
        string tg;
        @(posedge clk);
        b_opnd = x; b_amt = BA'(c); b_op = 2'(op); b_cin = cin;
        @(negedge clk);
        model(longint'(x), c, op, cin, BW, er, ec, tg);
        judge({tg, " wide"}, longint'(b_res), b_cy, b_ext, er, ec);
    endtask

    initial begin
        s_opnd = '0; s_amt = '0; s_op = 2'b00; s_cin = 1'b0;
        b_opnd = '0; b_amt = '0; b_op = 2'b00; b_cin = 1'b0;
        @(negedge clk);
        // Idle state: zero operand, zero amount keeps zero carry (R2).
        judge("R2 idle", longint'(s_res), s_cy, s_ext, 0, 1'b0);

        // Exhaustive sweep of the narrow copy: R1..R10.
        for (int op = 0; op < 4; op++) begin
            for (int ci = 0; ci < 2; ci++) begin
                for (int c = 0; c < (1 << SA); c++) begin
                    for (int x = 0; x < (1 << SW); x++) begin
                        longint unsigned er;
                        bit ec;
                        string tg;
                        @(posedge clk);
                        s_opnd = SW'(x); s_amt = SA'(c); s_op = 2'(op); s_cin = ci[0];
                        @(negedge clk);
                        model(longint'(x), c, op, ci[0], SW, er, ec, tg);
                        judge(tg, longint'(s_res), s_cy, s_ext, er, ec);
                    end
                end
            end
        end

        // Directed vectors at full width around the boundaries: R3..R8, R10.
        for (int op = 0; op < 4; op++) begin
            wide_vec(32'h8000_0001, 0,  op, 1'b1);
            wide_vec(32'h8000_0001, 1,  op, 1'b0);
            wide_vec(32'hC3A5_5A3C, 31, op, 1'b0);
            wide_vec(32'h7FFF_FFFE, 32, op, 1'b1);
            wide_vec(32'h8000_0001, 32, op, 1'b0);
            wide_vec(32'hFFFF_FFFF, 33, op, 1'b1);
            wide_vec(32'h9234_5678, 63, op, 1'b0);
            wide_vec(32'h1234_5679, 40, op, 1'b1);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired before the sweep finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule